// File: doc/BRIEF.md
# Compare-Match Timer Channel

One channel of a compare-match timer. A 32-bit up-counter advances on a count tick derived from the block clock by a selectable divider. Each time the counter equals a 32-bit compare value on a tick, a sticky match flag is set. Depending on the request-type field, the match can also drive a level interrupt or a one-cycle DMA request pulse. In periodic mode the counter goes back to zero on the matching tick, so the period is compare+1 ticks. In free-running mode it keeps counting, and a wrap from all ones to zero sets a sticky overflow flag.

Software reaches three registers through a simple word-indexed bus: control/status at word 0, counter at word 1 and compare at word 2. The byte offsets are 0x0, 0x4 and 0x8. The channel's bit of the shared start/stop register arrives on the `run` input. A counter write is not applied at once. It passes through a loader state machine, and a pending flag covers the write until the value is applied.

The loader has four states. IDLE accepts a counter write, and the transition "accept" moves it to SYNC1. SYNC1 always advances to SYNC2. SYNC2 always advances to APPLY. During APPLY the captured value is loaded into the counter, and the transition "retire" returns the loader to IDLE. The pending flag is high in SYNC1, SYNC2 and APPLY.

Top module: `cmt_channel`

## Requirements
- R1: After reset, control/status reads 0, the counter reads 0, compare reads 0xFFFFFFFF, and `irq` and `dma_req` are low.
- R2: The counter advances only on ticks while `run` is 1. While `run` is 0 the counter holds its value.
- R3: With periodic mode (control bit 8) set, a tick with counter equal to compare loads 0 and sets the match flag (bit 15). The period is compare+1 ticks.
- R4: The match flag (bit 15) and overflow flag (bit 14) are sticky. A control write with 0 in a flag bit clears that flag, and a 1 leaves it unchanged. If a hardware set and a clearing write fall in the same cycle, the flag ends up set.
- R5: A counter write (word 1) makes the pending flag (bit 13) read 1 on the three cycles after the write edge. From the fourth cycle the flag reads 0 and the counter holds the written value.
- R6: A counter write issued while the pending flag is 1 is ignored, and the first value is the one loaded.
- R7: Clock select (bits 2:0) gives one tick every 8 clocks for code 4, every 32 for code 5, every 128 for code 6 and every clock for code 7. Codes 0 to 3 give no ticks. The divider restarts whenever `run` is 0.
- R8: `irq` equals the match flag AND interrupt enable (bit 7) AND request type (bits 5:4) equal to 2.
- R9: With request type 1, `dma_req` is a one-cycle pulse on the cycle after each matching tick, and `irq` stays low.
- R10: In free-running mode (bit 8 clear), the counter continues past the compare value, which sets the match flag. A wrap from 0xFFFFFFFF to 0 with compare not equal to all ones sets the overflow flag (bit 14) and not the match flag.
- R11: The control fields (bits 8, 7, 5:4, 2:0) and the compare register read back what was written, and a control write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | This channel's start/stop bit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word index: 0 control/status, 1 counter, 2 compare |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt request |
| dma_req | output | 1 | One-cycle DMA request pulse |

## Verification
The hardest case to reach is a hardware match and a software flag clear landing on the same clock edge. The bench first parks the counter exactly at the compare value with `run` low, using a counter write that it lets retire. On one falling edge it then raises `run` and issues the clearing control write together, so both act on the next rising edge. A second case that needs care is a counter write issued during the pending window. The bench issues two writes on consecutive cycles and checks which value lands.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int CNT_W = 32;

    localparam int BIT_MATCH = 15;
    localparam int BIT_OVF   = 14;
    localparam int BIT_PEND  = 13;
    localparam int BIT_PER   = 8;
    localparam int BIT_IE    = 7;

    localparam logic [1:0] REQ_NONE = 2'd0;
    localparam logic [1:0] REQ_DMA  = 2'd1;
    localparam logic [1:0] REQ_IRQ  = 2'd2;

    localparam logic [1:0] ADR_CSR = 2'd0;
    localparam logic [1:0] ADR_CNT = 2'd1;
    localparam logic [1:0] ADR_CMP = 2'd2;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SYNC1 = 2'd1,
        LD_SYNC2 = 2'd2,
        LD_APPLY = 2'd3
    } ld_state_t;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
    parameter int DIV_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [DIV_W-1:0] pc;
    logic [DIV_W-1:0] limit;
    logic             valid;

    always_comb begin
        valid = 1'b1;
        unique case (sel)
            3'd4:    limit = DIV_W'(7);
            3'd5:    limit = DIV_W'(31);
            3'd6:    limit = DIV_W'(127);
            3'd7:    limit = '0;
            default: begin
                limit = '0;
                valid = 1'b0;
            end
        endcase
    end

    assign tick = run && valid && (pc == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pc <= '0;
        else if (!run || pc == limit) pc <= '0;
        else                          pc <= pc + 1'b1;
    end

    // R7: a divide-by-8 tick is never followed by another on the next cycle
    a_r7_div8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel == 3'd4 && $stable(sel)) |=> !tick);
endmodule

// File: rtl/cmt_loader.sv
module cmt_loader
    import cmt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    output logic         pending,
    output logic         apply,
    output logic [W-1:0] apply_data
);
    ld_state_t    state, state_nx;
    logic [W-1:0] shadow;

    always_comb begin
        state_nx = state;
        unique case (state)
            LD_IDLE:  if (wr_req) state_nx = LD_SYNC1;
            LD_SYNC1: state_nx = LD_SYNC2;
            LD_SYNC2: state_nx = LD_APPLY;
            LD_APPLY: state_nx = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           shadow <= '0;
        else if (state == LD_IDLE && wr_req)  shadow <= wr_data;
    end

    always_comb begin
        pending = 1'b1;
        apply   = 1'b0;
        unique case (state)
            LD_IDLE:  pending = 1'b0;
            LD_SYNC1: ;
            LD_SYNC2: ;
            LD_APPLY: apply = 1'b1;
        endcase
    end

    assign apply_data = shadow;

    // R6: a write during the pending window leaves the captured value alone
    a_r6_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && wr_req) |=> $stable(shadow));
    // R5: an accepted write raises the pending flag on the next cycle
    a_r5_pend_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && wr_req) |=> pending);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int W     = CNT_W,
    parameter int DIV_W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    output logic         irq,
    output logic         dma_req
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] cnt, cmp;
    logic         f_match, f_ovf;
    logic         c_per, c_ie;
    logic [1:0]   c_req;
    logic [2:0]   c_cks;

    logic         tick, pending, apply;
    logic [W-1:0] apply_data;
    logic         hit, wrap_ovf;
    logic         wr_csr, wr_cnt, wr_cmp;

    assign wr_csr = bus_wr && bus_addr == ADR_CSR;
    assign wr_cnt = bus_wr && bus_addr == ADR_CNT;
    assign wr_cmp = bus_wr && bus_addr == ADR_CMP;

    cmt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sel  (c_cks),
        .tick (tick)
    );

    cmt_loader #(.W(W)) u_ld (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_cnt),
        .wr_data   (bus_wdata[W-1:0]),
        .pending   (pending),
        .apply     (apply),
        .apply_data(apply_data)
    );

    assign hit      = tick && !apply && cnt == cmp;
    assign wrap_ovf = tick && !apply && cnt == ALL_ONES && cnt != cmp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (apply)          cnt <= apply_data;
        else if (hit && c_per)   cnt <= '0;
        else if (tick)           cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp <= ALL_ONES;
        else if (wr_cmp) cmp <= bus_wdata[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_per <= 1'b0;
            c_ie  <= 1'b0;
            c_req <= REQ_NONE;
            c_cks <= 3'd0;
        end else if (wr_csr) begin
            c_per <= bus_wdata[BIT_PER];
            c_ie  <= bus_wdata[BIT_IE];
            c_req <= bus_wdata[5:4];
            c_cks <= bus_wdata[2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_match <= 1'b0;
            f_ovf   <= 1'b0;
        end else begin
            f_match <= (f_match && !(wr_csr && !bus_wdata[BIT_MATCH])) || hit;
            f_ovf   <= (f_ovf   && !(wr_csr && !bus_wdata[BIT_OVF]))   || wrap_ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dma_req <= 1'b0;
        else        dma_req <= hit && c_req == REQ_DMA;
    end

    assign irq = f_match && c_ie && c_req == REQ_IRQ;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CSR: begin
                bus_rdata[BIT_MATCH] = f_match;
                bus_rdata[BIT_OVF]   = f_ovf;
                bus_rdata[BIT_PEND]  = pending;
                bus_rdata[BIT_PER]   = c_per;
                bus_rdata[BIT_IE]    = c_ie;
                bus_rdata[5:4]       = c_req;
                bus_rdata[2:0]       = c_cks;
            end
            ADR_CNT: bus_rdata[W-1:0] = cnt;
            ADR_CMP: bus_rdata[W-1:0] = cmp;
            default: bus_rdata = '0;
        endcase
    end

    // R2: with run low and no load, the counter holds
    a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !apply) |=> $stable(cnt));
    // R3: periodic match returns the counter to zero and sets the flag
    a_r3_periodic_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !apply && c_per && cnt == cmp) |=> (cnt == '0 && f_match));
    // R4: match flag stays set unless a control write clears it
    a_r4_sticky_match: assert property (@(posedge clk) disable iff (!rst_n)
        (f_match && !wr_csr) |=> f_match);
    // R10: overflow flag stays set unless a control write clears it
    a_r10_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (f_ovf && !wr_csr) |=> f_ovf);
endmodule

// File: tb/cmt_channel_test.sv
`timescale 1ns/1ps
module cmt_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, dma_req;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cmt_channel uut (
        .clk(clk), .rst_n(rst_n), .run(run), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .dma_req(dma_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_for(input int n);
        run = 1'b1;
        idle(n);
        run = 1'b0;
    endtask

    task automatic load_cnt(input logic [31:0] v);
        wr(2'd1, v);
        idle(4);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); check("R1 csr", d, 32'h0);
        rd(2'd1, d); check("R1 cnt", d, 32'h0);
        rd(2'd2, d); check("R1 cmp", d, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 dma", {31'b0, dma_req}, 32'h0);
    endtask

    task automatic t_run_freeze;
        logic [31:0] d;
        wr(2'd0, 32'h0000_0007);
        run_for(10);
        idle(5);
        rd(2'd1, d); check("R2 freeze after 10 ticks", d, 32'd10);
    endtask

    task automatic t_prescale;
        logic [31:0] d;
        load_cnt(32'h0);
        wr(2'd0, 32'h0000_0004); run_for(80);
        rd(2'd1, d); check("R7 div8", d, 32'd10);
        wr(2'd0, 32'h0000_0005); run_for(320);
        rd(2'd1, d); check("R7 div32", d, 32'd20);
        wr(2'd0, 32'h0000_0006); run_for(256);
        rd(2'd1, d); check("R7 div128", d, 32'd22);
        wr(2'd0, 32'h0000_0002); run_for(50);
        rd(2'd1, d); check("R7 code2 no ticks", d, 32'd22);
    endtask

    task automatic t_loader;
        logic [31:0] d;
        wr(2'd1, 32'h0000_0100);
        for (int i = 0; i < 3; i++) begin
            rd(2'd0, d); check("R5 pending high", {31'b0, d[13]}, 32'h1);
            idle(1);
        end
        rd(2'd0, d); check("R5 pending low", {31'b0, d[13]}, 32'h0);
        rd(2'd1, d); check("R5 value loaded", d, 32'h100);
        wr(2'd1, 32'h0000_0200);
        wr(2'd1, 32'h0000_0300);
        idle(4);
        rd(2'd1, d); check("R6 busy write ignored", d, 32'h200);
    endtask

    task automatic t_periodic;
        logic [31:0] d;
        wr(2'd2, 32'd4);
        rd(2'd2, d); check("R11 cmp readback", d, 32'd4);
        wr(2'd0, 32'h0000_0107);
        load_cnt(32'h0);
        run_for(4);
        rd(2'd1, d); check("R3 cnt at compare", d, 32'd4);
        rd(2'd0, d); check("R3 no match yet", {31'b0, d[15]}, 32'h0);
        run_for(1);
        rd(2'd1, d); check("R3 wrapped to 0", d, 32'd0);
        rd(2'd0, d); check("R3 match set", {31'b0, d[15]}, 32'h1);
        wr(2'd0, 32'h0000_8107);
        rd(2'd0, d); check("R4 write 1 keeps", {31'b0, d[15]}, 32'h1);
        wr(2'd0, 32'h0000_0107);
        rd(2'd0, d); check("R4 write 0 clears", {31'b0, d[15]}, 32'h0);
        rd(2'd0, d); check("R11 csr readback", d, 32'h0000_0107);
    endtask

    task automatic t_set_wins;
        logic [31:0] d;
        load_cnt(32'd4);
        run_for(5);
        rd(2'd0, d); check("R4 match preset", {31'b0, d[15]}, 32'h1);
        load_cnt(32'd4);
        run = 1'b1;
        wr(2'd0, 32'h0000_0107);
        run = 1'b0;
        rd(2'd0, d); check("R4 set beats clear", {31'b0, d[15]}, 32'h1);
        rd(2'd1, d); check("R4 cnt wrapped", d, 32'd0);
    endtask

    task automatic t_irq;
        wr(2'd0, 32'h0000_81A7);
        check("R8 irq on", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0000_8197);
        check("R8 irq off for dma type", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h0000_8127);
        check("R8 irq off without enable", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h0000_01A7);
        check("R8 irq off after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_dma;
        int pulses = 0;
        int irqs = 0;
        wr(2'd0, 32'h0000_0117);
        load_cnt(32'h0);
        run = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (dma_req) pulses++;
            if (irq) irqs++;
        end
        run = 1'b0;
        idle(1);
        if (dma_req) pulses++;
        check("R9 dma pulse count", pulses, 32'd2);
        check("R9 irq quiet", irqs, 32'd0);
    endtask

    task automatic t_overflow;
        logic [31:0] d;
        wr(2'd0, 32'h0000_0007);
        wr(2'd2, 32'h0000_0010);
        load_cnt(32'hFFFF_FFFE);
        run_for(2);
        rd(2'd1, d); check("R10 wrapped", d, 32'h0);
        rd(2'd0, d); check("R10 ovf set, no match", {16'b0, d[15:14], 14'b0}, 32'h0000_4000);
        wr(2'd0, 32'h0000_0007);
        wr(2'd2, 32'd3);
        load_cnt(32'h0);
        run_for(5);
        rd(2'd1, d); check("R10 continues past compare", d, 32'd5);
        rd(2'd0, d); check("R10 match in free-run", {16'b0, d[15:14], 14'b0}, 32'h0000_8000);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_run_freeze();
        t_prescale();
        t_loader();
        t_periodic();
        t_set_wins();
        t_irq();
        t_dma();
        t_overflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule